// File: doc/BRIEF.md
# Ordered Blue-Noise Monochrome Ditherer

This block reduces a live stream of 8-bit intensity pixels to one bit per pixel. Each incoming pixel arrives with its screen column and row. The block uses the low six bits of each coordinate to look up an 8-bit threshold in a 64 by 64 tile held in on-chip memory. The output bit is set when the pixel is brighter than that threshold. Because the tile is addressed by the coordinates modulo 64, the pattern repeats across the whole screen without any frame storage.

There is no error feedback between pixels, so every pixel's result depends only on its own value and position. The block accepts one pixel on every clock and never stalls. Its output is qualified by a valid flag and trails the input by exactly one clock. That cycle is the synchronous read of the threshold memory.

The default tile contents come from a multiplicative hash of the address. The hash spreads the thresholds across the full 8-bit range without regular structure. A different tile can be chosen through the `THR_MULT` parameter.

Top module: `dith_top`

## Requirements
- R1: When a result is valid, `bit_o` is 1 exactly when the pixel value is strictly greater than the threshold stored at address `{y_i[5:0], x_i[5:0]}`, where the row bits are the upper six address bits.
- R2: The threshold at address a (0..4095) is bits [31:24] of the 32-bit product (a+1)*THR_MULT mod 2^32. The default THR_MULT is 32'h9E3779B1.
- R3: Coordinate bits above bit 5 have no effect on the result, so the pattern tiles every 64 pixels in both directions.
- R4: A pixel presented with `valid_i` high at a rising clock edge produces `valid_o` high, together with its `bit_o`, in the cycle that follows that edge.
- R5: `valid_o` is low in the cycle after any edge where `valid_i` was low, and `bit_o` is 0 whenever `valid_o` is low.
- R6: A pixel of value 0 always gives `bit_o` = 0.
- R7: A pixel of value 255 gives `bit_o` = 1 at every position whose threshold is below 255.
- R8: One pixel is accepted on every clock with no stall. Back-to-back valid pixels each yield their own result on consecutive cycles.
- R9: While `rst_ni` is low, `valid_o` and `bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel qualifier |
| pixel_i | input | 8 | Pixel intensity |
| x_i | input | X_W (12) | Pixel column |
| y_i | input | Y_W (12) | Pixel row |
| valid_o | output | 1 | Result qualifier |
| bit_o | output | 1 | Dithered monochrome bit |

## Verification
Every result, both `valid_o` and `bit_o`, is due exactly one rising edge after the pixel that caused it. The bench drives each pixel on a falling edge. It then compares the outputs on the next falling edge against values it predicted from that pixel and from the hash formula. These checks run half a cycle clear of the register updates. Reset outputs are sampled while reset is held, and the tiling check replays one low-bit position under many different high coordinate bits.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned TILE_L = 6;
  localparam int unsigned ADDR_W = 2 * TILE_L;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // hashed threshold: top PIX_W bits of (a+1)*mult
  function automatic pix_t thr_hash(input int unsigned a, input logic [31:0] mult);
    logic [31:0] prod;
    prod = (32'(a) + 32'd1) * mult;
    return prod[31 -: PIX_W];
  endfunction
endpackage

// File: rtl/dith_thr_rom.sv
module dith_thr_rom
  import dith_pkg::*;
#(
  parameter logic [31:0] THR_MULT = 32'h9E3779B1
) (
  input  logic  clk_i,
  input  addr_t addr_i,
  output pix_t  thr_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  pix_t mem [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) mem[i] = thr_hash(i, THR_MULT);
  end

  // synchronous read, no reset on data
  always_ff @(posedge clk_i) thr_o <= mem[addr_i];
endmodule

// File: rtl/dith_align.sv
module dith_align
  import dith_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  pix_t pixel_i,
  output logic valid_o,
  output pix_t pixel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pixel_o <= '0;
    end else begin
      valid_o <= valid_i;
      pixel_o <= pixel_i;
    end
  end
endmodule

// File: rtl/dith_cmp.sv
module dith_cmp
  import dith_pkg::*;
(
  input  logic valid_i,
  input  pix_t pixel_i,
  input  pix_t thr_i,
  output logic bit_o
);
  always_comb bit_o = valid_i && (pixel_i > thr_i);
endmodule

// File: rtl/dith_top.sv
module dith_top
  import dith_pkg::*;
#(
  parameter int unsigned X_W      = 12,
  parameter int unsigned Y_W      = 12,
  parameter logic [31:0] THR_MULT = 32'h9E3779B1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [7:0]     pixel_i,
  input  logic [X_W-1:0] x_i,
  input  logic [Y_W-1:0] y_i,
  output logic           valid_o,
  output logic           bit_o
);
  addr_t rd_addr;
  pix_t  thr_q;
  pix_t  pix_q;
  logic  vld_q;

  // tile index = coordinates modulo 64
  assign rd_addr = {y_i[TILE_L-1:0], x_i[TILE_L-1:0]};

  generate
    if (X_W > TILE_L) begin : g_xhi
      logic unused_xhi;
      assign unused_xhi = ^x_i[X_W-1:TILE_L];
    end
    if (Y_W > TILE_L) begin : g_yhi
      logic unused_yhi;
      assign unused_yhi = ^y_i[Y_W-1:TILE_L];
    end
  endgenerate

  dith_thr_rom #(.THR_MULT(THR_MULT)) u_rom (
    .clk_i (clk_i),
    .addr_i(rd_addr),
    .thr_o (thr_q)
  );

  dith_align u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .pixel_i(pixel_i),
    .valid_o(vld_q),
    .pixel_o(pix_q)
  );

  dith_cmp u_cmp (
    .valid_i(vld_q),
    .pixel_i(pix_q),
    .thr_i  (thr_q),
    .bit_o  (bit_o)
  );

  assign valid_o = vld_q;
endmodule

// File: rtl/dith_chk.sv
module dith_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] pixel_i,
  input logic       valid_o,
  input logic       bit_o,
  input logic [7:0] thr_i
);
  assert_valid_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_bit_qual_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !bit_o);

  assert_black_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pixel_i == 8'd0) |=> !bit_o);

  assert_white_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pixel_i == 8'd255) |=> (bit_o || thr_i == 8'd255));

  always_comb begin
    if (!rst_ni) assert_reset_R9: assert (!valid_o && !bit_o);
  end
endmodule

bind dith_top dith_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .pixel_i(pixel_i),
  .valid_o(valid_o),
  .bit_o  (bit_o),
  .thr_i  (thr_q)
);

// File: tb/tb_dith_top.sv
module tb_dith_top;
  localparam int X_W = 12;
  localparam int Y_W = 12;
  localparam logic [31:0] MULT = 32'h9E3779B1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid_i = 1'b0;
  logic [7:0]     pixel_i = '0;
  logic [X_W-1:0] x_i = '0;
  logic [Y_W-1:0] y_i = '0;
  logic           valid_o, bit_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit         exp_v;
  bit         exp_b;
  string      exp_tag;

  always #5 clk = ~clk;

  dith_top #(.X_W(X_W), .Y_W(Y_W), .THR_MULT(MULT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pixel_i(pixel_i),
    .x_i(x_i), .y_i(y_i), .valid_o(valid_o), .bit_o(bit_o)
  );

  // R2 threshold formula
  function automatic logic [7:0] ref_thr(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
    logic [31:0] a, p;
    a = {20'd0, y[5:0], x[5:0]};
    p = (a + 32'd1) * MULT;
    return p[31:24];
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // check previous pixel at falling edge, then drive the next one
  task automatic step(input bit v, input logic [7:0] p, input logic [X_W-1:0] x,
                      input logic [Y_W-1:0] y, input string tag);
    @(negedge clk);
    check(exp_v ? "R4" : "R5", "valid_o", valid_o, exp_v);
    check(exp_tag, "bit_o", bit_o, exp_b);
    valid_i = v; pixel_i = p; x_i = x; y_i = y;
    exp_v = v;
    exp_b = v && (p > ref_thr(x, y));
    exp_tag = v ? tag : "R5";
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    exp_v = 0; exp_b = 0; exp_tag = "R5";
    repeat (3) @(negedge clk);
    check("R9", "valid_o in reset", valid_o, 1'b0);
    check("R9", "bit_o in reset", bit_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R6 black at every tested position
    for (int i = 0; i < 64; i++) step(1, 8'd0, X_W'(i * 37), Y_W'(i * 11), "R6");
    // R7 white
    for (int i = 0; i < 64; i++) step(1, 8'd255, X_W'(i * 5), Y_W'(i * 53), "R7");
    // R1 equal-to-threshold is not greater; threshold+1 is
    for (int i = 0; i < 32; i++) begin
      logic [7:0] t;
      t = ref_thr(X_W'(i), Y_W'(i + 3));
      step(1, t, X_W'(i), Y_W'(i + 3), "R1");
      if (t != 8'd255) step(1, t + 8'd1, X_W'(i), Y_W'(i + 3), "R1");
    end
    // R3 aliasing through high coordinate bits
    for (int i = 0; i < 64; i++)
      step(1, 8'(ref_thr(12'd5, 12'd7) + (i % 2)), X_W'(5 + 64 * i), Y_W'(7 + 64 * (63 - i)), "R3");
    // R5 idle gaps with garbage on data
    for (int i = 0; i < 8; i++) step(0, 8'hFF, X_W'(i), '0, "R5");
    // R8 back-to-back plus random valid
    for (int i = 0; i < 3000; i++) begin
      bit v;
      v = (i < 200) ? 1'b1 : ($urandom % 4 != 0);
      step(v, 8'($urandom), X_W'($urandom), Y_W'($urandom), (i < 200) ? "R8" : "R1");
    end
    step(0, '0, '0, '0, "R5");
    step(0, '0, '0, '0, "R5");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule